// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block holds one 32-bit status and control word that records why the system last came out of reset. It also lets software ask for a new reset. Five flags live in the top five bits of the word. The remaining bits always read zero.

- Bit 31 marks a power-on reset.
- Bit 30 requests, or records, a soft power-on reset.
- Bit 29 requests, or records, a soft externally initiated reset.
- Bit 28 records a button power-on reset.
- Bit 27 records a button externally initiated reset.

Software reaches the word through a simple register bus. The bus decodes an 8-byte window, and only the upper 32-bit word of that window is live. A write with bit 30 or bit 29 set produces a one-cycle `sys_rst_req` pulse, which a separate reset sequencer turns into the actual reset. The sequencer reports each completed reset back to the block on `sys_rst`.

A small saturating counter survives these system resets and is cleared only by the power-up reset `por_n`. The counter decides whether the next `sys_rst` is reported as a power-on reset. A soft power-on request clears the counter, so the reset that follows it is marked as power-on again. A soft externally initiated request leaves the counter as it is.

The register bus is a control path. It has no back-pressure: a read returns data combinationally in the same cycle, and a write takes effect at the next clock edge.

Top module: `reset_cause_reg`

## Requirements
- R1: After `por_n` is deasserted, the live word reads 0x0000_0000 and `sys_rst_req` is low.
- R2: Bits 26..0 of the live word always read zero, whatever value was written.
- R3: Writing a 1 to bit 31, bit 28 or bit 27 of the live word clears that bit. Writing a 0 to any of these bits leaves it unchanged.
- R4: Bits 30 and 29 become set when written with 1. Writing 0 never clears them.
- R5: A write with bit 30 set drives `sys_rst_req` high for exactly the next cycle and clears the reset counter. The following `sys_rst` therefore loads the word with exactly 0x8000_0000.
- R6: A write with bit 29 set and bit 30 clear drives `sys_rst_req` high for exactly the next cycle and leaves the counter unchanged. When the counter is nonzero, the following `sys_rst` leaves the word unchanged.
- R7: When the counter is zero, a `sys_rst` cycle loads the word with exactly 0x8000_0000. When the counter is nonzero, the word is unchanged. In both cases the counter increments.
- R8: The counter saturates at 2**CNT_W-1. Any number of `sys_rst` cycles without a soft power-on request never reports a second power-on.
- R9: The word is live only at window offset 4 (address bit 2 = 1). Offset 0 reads zero, and writes to offset 0 change nothing and raise no request.
- R10: A high `btn_por` sets bit 28 and a high `btn_ext` sets bit 27. A button set wins over a clear written in the same cycle.
- R11: An access whose address lies outside the window reads zero. A write outside the window changes nothing.
- R12: A bus write in a `sys_rst` cycle is ignored. It changes no bit, raises no request and does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up reset, active low; clears the word and the counter |
| sys_rst | input | 1 | One cycle per completed system reset, driven by the reset sequencer |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| btn_por | input | 1 | Button power-on reset indication |
| btn_ext | input | 1 | Button externally initiated reset indication |
| sys_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Corruption of the status word shows on the next read of offset 4. It is either a flag that ignores its clear, a flag that refuses to be set, or stray bits in the unused low field. A corrupted reset counter stays hidden until the next `sys_rst`. The fault then appears as bit 31 being loaded or not loaded when it should not be, and a read after that reset exposes it. A faulty request path shows within one cycle of the write, as a missing, stretched or spurious `sys_rst_req` pulse.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] LIVE_MASK   = 32'hF800_0000;
  localparam logic [REG_W-1:0] CLEAR_MASK  = 32'h9800_0000;
  localparam logic [REG_W-1:0] SET_MASK    = 32'h6000_0000;
  localparam logic [REG_W-1:0] POWERUP_VAL = 32'h8000_0000;
  localparam int B_SOFT_POR = 30;
  localparam int B_SOFT_EXT = 29;
  localparam int N_BTN      = 2;
  // button i sets bit BTN_BASE - i : index 0 -> 28, index 1 -> 27
  localparam int BTN_BASE   = 28;
endpackage

// File: rtl/rcr_bus_decode.sv
module rcr_bus_decode
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [REG_W-1:0]  word,
  output logic              wr_live,
  output logic [REG_W-1:0]  wr_val,
  output logic [REG_W-1:0]  rdata
);
  localparam int HI = ADDR_W - 1;

  logic in_win;
  logic live;

  always_comb begin
    in_win  = (addr[HI:3] == WIN_BASE[HI:3]);
    live    = en && in_win && addr[2];
    wr_live = live && we;
    wr_val  = wdata & LIVE_MASK;
    rdata   = (live && !we) ? word : '0;
  end
endmodule

// File: rtl/rcr_boot_counter.sv
module rcr_boot_counter #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic bump,
  input  logic clear,
  output logic first
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (bump) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clear) begin
      cnt_q <= '0;
    end
  end

  assign first = (cnt_q == '0);
endmodule

// File: rtl/rcr_status_bits.sv
module rcr_status_bits
  import rcr_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst,
  input  logic             load_pwr,
  input  logic             wr_live,
  input  logic [REG_W-1:0] wr_val,
  input  logic [N_BTN-1:0] btn,
  output logic [REG_W-1:0] word
);
  logic [REG_W-1:0] btn_bits;
  logic [REG_W-1:0] base_nxt;
  logic [REG_W-1:0] word_q;

  always_comb begin
    btn_bits = '0;
    for (int i = 0; i < N_BTN; i++) btn_bits[BTN_BASE-i] = btn[i];
  end

  always_comb begin
    base_nxt = word_q;
    if (sys_rst) begin
      if (load_pwr) base_nxt = POWERUP_VAL;
    end else if (wr_live) begin
      base_nxt = (word_q & ~(wr_val & CLEAR_MASK)) | (wr_val & SET_MASK);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) word_q <= '0;
    else        word_q <= (base_nxt | btn_bits) & LIVE_MASK;
  end

  assign word = word_q;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              btn_por,
  input  logic              btn_ext,
  output logic              sys_rst_req
);
  logic             wr_hit;
  logic             wr_eff;
  logic [REG_W-1:0] wr_val;
  logic [REG_W-1:0] stat_q;
  logic             first;
  logic             req_q;

  rcr_bus_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .en(bus_en), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .word(stat_q), .wr_live(wr_hit), .wr_val(wr_val), .rdata(bus_rdata)
  );

  assign wr_eff = wr_hit && !sys_rst;

  rcr_boot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .bump(sys_rst),
    .clear(wr_eff && wr_val[B_SOFT_POR]), .first(first)
  );

  rcr_status_bits u_bits (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .load_pwr(first),
    .wr_live(wr_eff), .wr_val(wr_val), .btn({btn_ext, btn_por}),
    .word(stat_q)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) req_q <= 1'b0;
    else        req_q <= wr_eff && (wr_val[B_SOFT_POR] || wr_val[B_SOFT_EXT]);
  end

  assign sys_rst_req = req_q;
endmodule

// File: rtl/reset_cause_chk.sv
module reset_cause_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0040
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              btn_por,
  input logic              btn_ext,
  input logic              sys_rst_req,
  input logic [31:0]       stat
);
  logic upper_wr;
  logic req_cause;
  assign upper_wr  = bus_en && bus_we && bus_addr[2] && !sys_rst &&
                     (bus_addr[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3]);
  assign req_cause = upper_wr && (bus_wdata[30] || bus_wdata[29]);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[26:0] == 27'd0);

  a_r9_lower_word_zero: assert property (@(posedge clk) disable iff (!por_n)
    (bus_en && !bus_addr[2]) |-> bus_rdata == 32'd0);

  a_r5_req_has_cause: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_req |-> $past(req_cause));

  a_r4_soft_bits_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (stat[30] && !sys_rst) |=> stat[30]);

  a_r3_clear_power_flag: assert property (@(posedge clk) disable iff (!por_n)
    (upper_wr && bus_wdata[31]) |=> !stat[31]);

  a_r10_button_sets: assert property (@(posedge clk) disable iff (!por_n)
    (btn_por && btn_ext) |=> (stat[28] && stat[27]));
endmodule

bind reset_cause_reg reset_cause_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .btn_por(btn_por), .btn_ext(btn_ext), .sys_rst_req(sys_rst_req), .stat(stat_q)
);

// File: tb/reset_cause_reg_test.sv
module reset_cause_reg_test;
  localparam int AW = 16;
  localparam logic [AW-1:0] UP  = 16'h0044;
  localparam logic [AW-1:0] LO  = 16'h0040;
  localparam logic [AW-1:0] OUT = 16'h0084;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sys_rst = 1'b0;
  logic bus_en = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic btn_por = 1'b0;
  logic btn_ext = 1'b0;
  logic sys_rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  int req_seen = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  reset_cause_reg #(.ADDR_W(AW), .WIN_BASE(16'h0040), .CNT_W(2)) uut (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .btn_por(btn_por), .btn_ext(btn_ext), .sys_rst_req(sys_rst_req)
  );

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (sys_rst_req) req_seen++;
    if (bus_en && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic cmp1(input logic act, input logic exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    bus_en = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic srst();
    sys_rst = 1;
    @(posedge clk); #1;
    sys_rst = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1;
    idle();
    // R1 reset state
    rd(UP, 32'h0, "R1");
    cmp1(sys_rst_req, 1'b0, "R1 req");
    // R7 first reset loads power-on
    srst();
    rd(UP, 32'h8000_0000, "R7");
    rd(LO, 32'h0, "R9 lower read");
    // R9 lower word writes ignored
    wr(LO, 32'hFFFF_FFFF);
    cmp1(sys_rst_req, 1'b0, "R9 req");
    rd(UP, 32'h8000_0000, "R9");
    // R11 out of window
    wr(OUT, 32'hF800_0000);
    cmp1(sys_rst_req, 1'b0, "R11 req");
    rd(UP, 32'h8000_0000, "R11");
    rd(OUT, 32'h0, "R11 read");
    // R3 clear bit 31
    wr(UP, 32'h8000_0000);
    rd(UP, 32'h0, "R3 bit31");
    // R10 buttons
    btn_por = 1; idle(); btn_por = 0;
    btn_ext = 1; idle(); btn_ext = 0;
    rd(UP, 32'h1800_0000, "R10");
    // R2 unused bits
    wr(UP, 32'h07FF_FFFF);
    rd(UP, 32'h1800_0000, "R2");
    // R3 clear bit 28 only
    wr(UP, 32'h1000_0000);
    rd(UP, 32'h0800_0000, "R3 bit28");
    // R10 set wins over same-cycle clear
    btn_ext = 1; wr(UP, 32'h0800_0000); btn_ext = 0;
    rd(UP, 32'h0800_0000, "R10 set wins");
    wr(UP, 32'h0800_0000);
    rd(UP, 32'h0, "R3 bit27");
    // R6 soft external request, counter is 1
    wr(UP, 32'h2000_0000);
    cmp1(sys_rst_req, 1'b1, "R6 pulse");
    idle();
    cmp1(sys_rst_req, 1'b0, "R6 pulse width");
    srst();
    rd(UP, 32'h2000_0000, "R6 no power-on");
    // R4 writing zero keeps bit 29
    wr(UP, 32'h0);
    rd(UP, 32'h2000_0000, "R4");
    // R5 soft power-on request
    wr(UP, 32'h4000_0000);
    cmp1(sys_rst_req, 1'b1, "R5 pulse");
    idle();
    cmp1(sys_rst_req, 1'b0, "R5 pulse width");
    rd(UP, 32'h6000_0000, "R4 set");
    srst();
    rd(UP, 32'h8000_0000, "R5 power-on again");
    // R12 write during sys_rst ignored (counter 1 -> 2)
    sys_rst = 1;
    wr(UP, 32'hC000_0000);
    sys_rst = 0;
    cmp1(sys_rst_req, 1'b0, "R12 req");
    rd(UP, 32'h8000_0000, "R12");
    // R8 saturation: counter 2, four more resets must not report power-on
    wr(UP, 32'h8000_0000);
    repeat (4) srst();
    rd(UP, 32'h0, "R8");
    idle(); idle();
    n_cmp++;
    if (req_seen != 2) begin
      n_bad++;
      $display("FAIL R5/R6 pulse count: got %0d expected 2", req_seen);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule